// File: doc/BRIEF.md
# Inline Pre-Trade Order Risk Gate

This block sits in the order path between a trading engine and an exchange link. It receives one parsed order per cycle (symbol index, side, price, quantity, client id) and runs five rule evaluations in parallel: a price ceiling, a size window, a per-client credit ceiling, a restricted-symbol lookup and a per-client daily volume ceiling. An order that passes leaves on the egress stream stamped with a free-running timestamp. An order that fails never reaches egress. Instead, a reject record naming the broken rule goes back toward the order source.

Limits and the 256-entry restricted-symbol bitmap are written through a plain register write port. Per-client running totals of credit exposure and traded volume advance only on accepted orders, and a single pulse clears them. A monitor-only mode evaluates every rule but routes every order to egress. In that mode the violated rule code rides along with the forwarded order.

Both output streams are valid/ready. A record that is offered with ready low stays fixed until it is taken. While either output is held, the block deasserts ingress ready and the whole pipeline freezes.

Top module: `ord_risk_gate`

## Requirements
- R1: Each order is given a 3-bit rule code, as follows:
  - 1: price above the price limit.
  - 2: quantity zero or above the size limit.
  - 3: the client's credit total plus price×quantity exceeds the credit limit.
  - 4: the restricted bit of the symbol is set.
  - 5: the client's volume total plus quantity exceeds the volume limit.
  - 0: none of the above.
- R2: When several rules fail together, the lowest nonzero code is reported.
- R3: A result becomes valid exactly 3 cycles after the ingress handshake cycle when neither output is stalled. This holds whatever the order contents. Back-to-back orders are accepted at one per cycle.
- R4: A passing order appears on egress with its fields unchanged. Its out_ts equals the timestamp counter value in the cycle before egress valid first rises. The counter is 0 in the first cycle after reset release and increments every cycle. Outside monitor mode, a failing order never appears on egress.
- R5: Outside monitor mode, a failing order produces exactly one reject record with its client id, its symbol and its nonzero rule code. Egress and reject are never valid together.
- R6: With monitor_en high, every order goes to egress and none to reject. out_rule carries the order's rule code, which is 0 for a passing order.
- R7: Credit totals are kept per client and grow by price×quantity only when an order passes. A total plus exposure equal to the limit passes.
- R8: Volume totals are kept per client and grow by quantity only when an order passes. A total equal to the limit passes.
- R9: While an offered output has its ready low, in_ready is low and the offered record holds stable.
- R10: A totals_clear pulse sets every client's credit and volume totals to zero.
- R11: The configuration write port uses these addresses:
  - 0: price limit.
  - 1: size limit.
  - 2: credit limit.
  - 3: volume limit.
  - 8 to 15: restricted bitmap words. Symbol s maps to word s/32, bit s%32.
  A write in the same cycle as an order's ingress handshake applies from the next order on.
- R12: After reset:
  - both outputs are invalid and in_ready is high;
  - every limit is all ones;
  - no symbol is restricted;
  - all totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress order valid |
| in_ready | output | 1 | Ingress ready, low while an output is held |
| in_sym | input | 8 | Symbol index |
| in_side | input | 1 | Side flag, passed through |
| in_price | input | PX_W | Price |
| in_qty | input | QTY_W | Quantity |
| in_client | input | CL_W | Client id |
| out_valid | output | 1 | Egress valid |
| out_ready | input | 1 | Egress ready |
| out_sym | output | 8 | Egress symbol |
| out_side | output | 1 | Egress side |
| out_price | output | PX_W | Egress price |
| out_qty | output | QTY_W | Egress quantity |
| out_client | output | CL_W | Egress client id |
| out_ts | output | TS_W | Timestamp stamped on egress |
| out_rule | output | 3 | Rule code (nonzero only in monitor mode) |
| rej_valid | output | 1 | Reject record valid |
| rej_ready | input | 1 | Reject ready |
| rej_client | output | CL_W | Rejected order's client id |
| rej_sym | output | 8 | Rejected order's symbol |
| rej_code | output | 3 | Violated rule code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| monitor_en | input | 1 | Monitor-only mode |
| totals_clear | input | 1 | Clears all per-client totals |

## Verification
The bench sends three same-client orders back to back. Each must see the totals left by the order ahead of it: a gate that updated totals late would pass an order over the credit limit, and one that counted rejected orders would refuse the boundary order that lands exactly on the limit. Orders that break several rules at once expose a wrong priority as a wrong code. A limit write in the handshake cycle of an order catches a design that applies new limits to the order already in flight. Stalling each output separately shows whether a held record drifts, drops, or lets new orders overwrite it.

// File: rtl/orq_pkg.sv
package orq_pkg;
  localparam int unsigned SYM_W  = 8;
  localparam int unsigned CFG_AW = 4;
  localparam int unsigned CFG_DW = 32;

  typedef enum logic [2:0] {
    RC_PASS     = 3'd0,
    RC_PRICE    = 3'd1,
    RC_SIZE     = 3'd2,
    RC_CREDIT   = 3'd3,
    RC_RESTRICT = 3'd4,
    RC_VOLUME   = 3'd5
  } rule_code_e;

  localparam logic [CFG_AW-1:0] A_PX_LIM  = 4'd0;
  localparam logic [CFG_AW-1:0] A_QTY_LIM = 4'd1;
  localparam logic [CFG_AW-1:0] A_CR_LIM  = 4'd2;
  localparam logic [CFG_AW-1:0] A_VO_LIM  = 4'd3;
endpackage

// File: rtl/orq_cfg_regs.sv
module orq_cfg_regs
  import orq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  input  logic [SYM_W-1:0]  sym,
  output logic [CFG_DW-1:0] px_lim,
  output logic [CFG_DW-1:0] qty_lim,
  output logic [CFG_DW-1:0] cr_lim,
  output logic [CFG_DW-1:0] vo_lim,
  output logic              sym_blk
);
  localparam int NBITS  = 2 ** SYM_W;
  localparam int NWORD  = NBITS / CFG_DW;
  localparam int WSEL_W = $clog2(NWORD);

  logic [NBITS-1:0] bitmap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_lim  <= '1;
      qty_lim <= '1;
      cr_lim  <= '1;
      vo_lim  <= '1;
    end else if (we && !addr[CFG_AW-1]) begin
      case (addr)
        A_PX_LIM:  px_lim  <= wdata;
        A_QTY_LIM: qty_lim <= wdata;
        A_CR_LIM:  cr_lim  <= wdata;
        A_VO_LIM:  vo_lim  <= wdata;
        default: ;
      endcase
    end
  end

  generate
    for (genvar w = 0; w < NWORD; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bitmap[w*CFG_DW +: CFG_DW] <= '0;
        else if (we && addr[CFG_AW-1] && (addr[WSEL_W-1:0] == WSEL_W'(w)))
          bitmap[w*CFG_DW +: CFG_DW] <= wdata;
      end
    end
  endgenerate

  assign sym_blk = bitmap[sym];
endmodule

// File: rtl/orq_client_table.sv
module orq_client_table #(
  parameter int CL_W  = 4,
  parameter int EXP_W = 32,
  parameter int QTY_W = 16,
  parameter int CR_W  = 40,
  parameter int VO_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd_en,
  input  logic [CL_W-1:0]  cl,
  input  logic [EXP_W-1:0] upd_exp,
  input  logic [QTY_W-1:0] upd_qty,
  output logic [CR_W-1:0]  cr_tot,
  output logic [VO_W-1:0]  vo_tot
);
  localparam int NCL = 2 ** CL_W;

  logic [CR_W-1:0] cr_q [NCL];
  logic [VO_W-1:0] vo_q [NCL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCL; i++) begin
        cr_q[i] <= '0;
        vo_q[i] <= '0;
      end
    end else if (clear) begin
      for (int i = 0; i < NCL; i++) begin
        cr_q[i] <= '0;
        vo_q[i] <= '0;
      end
    end else if (upd_en) begin
      cr_q[cl] <= cr_q[cl] + CR_W'(upd_exp);
      vo_q[cl] <= vo_q[cl] + VO_W'(upd_qty);
    end
  end

  assign cr_tot = cr_q[cl];
  assign vo_tot = vo_q[cl];
endmodule

// File: rtl/orq_rule_eval.sv
module orq_rule_eval
  import orq_pkg::*;
#(
  parameter int PX_W  = 16,
  parameter int QTY_W = 16,
  parameter int EXP_W = 32,
  parameter int CR_W  = 40,
  parameter int VO_W  = 32
) (
  input  logic [PX_W-1:0]   px,
  input  logic [QTY_W-1:0]  qty,
  input  logic [CFG_DW-1:0] px_lim,
  input  logic [CFG_DW-1:0] qty_lim,
  input  logic [CFG_DW-1:0] cr_lim,
  input  logic [CFG_DW-1:0] vo_lim,
  input  logic              blk,
  input  logic [CR_W-1:0]   cr_tot,
  input  logic [VO_W-1:0]   vo_tot,
  output logic [EXP_W-1:0]  expo,
  output rule_code_e        code
);
  localparam int NRULE = 5;
  localparam int CW    = 64;

  logic [NRULE:1] fail;

  always_comb begin
    expo    = EXP_W'(px) * EXP_W'(qty);
    fail[1] = CW'(px) > CW'(px_lim);
    fail[2] = (qty == '0) || (CW'(qty) > CW'(qty_lim));
    fail[3] = (CW'(cr_tot) + CW'(expo)) > CW'(cr_lim);
    fail[4] = blk;
    fail[5] = (CW'(vo_tot) + CW'(qty)) > CW'(vo_lim);
    code = RC_PASS;
    for (int i = NRULE; i >= 1; i--)
      if (fail[i]) code = rule_code_e'(3'(i));
  end
endmodule

// File: rtl/ord_risk_gate.sv
module ord_risk_gate
  import orq_pkg::*;
#(
  parameter int PX_W  = 16,
  parameter int QTY_W = 16,
  parameter int CL_W  = 4,
  parameter int TS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SYM_W-1:0]  in_sym,
  input  logic              in_side,
  input  logic [PX_W-1:0]   in_price,
  input  logic [QTY_W-1:0]  in_qty,
  input  logic [CL_W-1:0]   in_client,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  out_sym,
  output logic              out_side,
  output logic [PX_W-1:0]   out_price,
  output logic [QTY_W-1:0]  out_qty,
  output logic [CL_W-1:0]   out_client,
  output logic [TS_W-1:0]   out_ts,
  output logic [2:0]        out_rule,
  output logic              rej_valid,
  input  logic              rej_ready,
  output logic [CL_W-1:0]   rej_client,
  output logic [SYM_W-1:0]  rej_sym,
  output logic [2:0]        rej_code,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              monitor_en,
  input  logic              totals_clear
);
  localparam int EXP_W = PX_W + QTY_W;
  localparam int CR_W  = EXP_W + 8;
  localparam int VO_W  = QTY_W + 16;

  logic              adv;
  logic [TS_W-1:0]   ts_q;

  // configuration view
  logic [CFG_DW-1:0] px_lim, qty_lim, cr_lim, vo_lim;
  logic              blk_now;

  // stage 1: captured order plus a snapshot of the limits in force at ingress
  logic              s1_v, s1_side, s1_blk;
  logic [SYM_W-1:0]  s1_sym;
  logic [PX_W-1:0]   s1_px;
  logic [QTY_W-1:0]  s1_qty;
  logic [CL_W-1:0]   s1_cl;
  logic [CFG_DW-1:0] s1_pxl, s1_qtl, s1_crl, s1_vol;

  // stage 2: order with its verdict
  logic              s2_v, s2_side;
  logic [SYM_W-1:0]  s2_sym;
  logic [PX_W-1:0]   s2_px;
  logic [QTY_W-1:0]  s2_qty;
  logic [CL_W-1:0]   s2_cl;
  rule_code_e        s2_code;

  logic [CR_W-1:0]   cr_tot;
  logic [VO_W-1:0]   vo_tot;
  logic [EXP_W-1:0]  expo;
  rule_code_e        code;
  logic              s2_fwd;

  assign adv      = !(out_valid && !out_ready) && !(rej_valid && !rej_ready);
  assign in_ready = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  orq_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sym(in_sym), .px_lim(px_lim), .qty_lim(qty_lim), .cr_lim(cr_lim),
    .vo_lim(vo_lim), .sym_blk(blk_now)
  );

  orq_client_table #(
    .CL_W(CL_W), .EXP_W(EXP_W), .QTY_W(QTY_W), .CR_W(CR_W), .VO_W(VO_W)
  ) u_tot (
    .clk(clk), .rst_n(rst_n), .clear(totals_clear),
    .upd_en(adv && s1_v && (code == RC_PASS)),
    .cl(s1_cl), .upd_exp(expo), .upd_qty(s1_qty),
    .cr_tot(cr_tot), .vo_tot(vo_tot)
  );

  orq_rule_eval #(
    .PX_W(PX_W), .QTY_W(QTY_W), .EXP_W(EXP_W), .CR_W(CR_W), .VO_W(VO_W)
  ) u_eval (
    .px(s1_px), .qty(s1_qty), .px_lim(s1_pxl), .qty_lim(s1_qtl),
    .cr_lim(s1_crl), .vo_lim(s1_vol), .blk(s1_blk),
    .cr_tot(cr_tot), .vo_tot(vo_tot), .expo(expo), .code(code)
  );

  // pipeline control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
    end
  end

  // pipeline data, no reset needed
  always_ff @(posedge clk) begin
    if (adv) begin
      s1_sym  <= in_sym;    s1_side <= in_side;  s1_px  <= in_price;
      s1_qty  <= in_qty;    s1_cl   <= in_client;
      s1_pxl  <= px_lim;    s1_qtl  <= qty_lim;  s1_crl <= cr_lim;
      s1_vol  <= vo_lim;    s1_blk  <= blk_now;
      s2_sym  <= s1_sym;    s2_side <= s1_side;  s2_px  <= s1_px;
      s2_qty  <= s1_qty;    s2_cl   <= s1_cl;    s2_code <= code;
    end
  end

  assign s2_fwd = (s2_code == RC_PASS) || monitor_en;

  // stage 3: routing and stamping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;  rej_valid <= 1'b0;
      out_sym    <= '0;    out_side  <= 1'b0;  out_price <= '0;
      out_qty    <= '0;    out_client <= '0;   out_ts    <= '0;
      out_rule   <= '0;    rej_client <= '0;   rej_sym   <= '0;
      rej_code   <= '0;
    end else if (adv) begin
      out_valid  <= s2_v && s2_fwd;
      rej_valid  <= s2_v && !s2_fwd;
      out_sym    <= s2_sym;  out_side <= s2_side;  out_price <= s2_px;
      out_qty    <= s2_qty;  out_client <= s2_cl;  out_ts    <= ts_q;
      out_rule   <= s2_code;
      rej_client <= s2_cl;   rej_sym  <= s2_sym;   rej_code  <= s2_code;
    end
  end
endmodule

// File: rtl/orq_gate_chk.sv
module orq_gate_chk #(
  parameter int PX_W = 16,
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [PX_W-1:0] out_price,
  input logic [TS_W-1:0] out_ts,
  input logic            rej_valid,
  input logic            rej_ready,
  input logic [2:0]      rej_code
);
  p_one_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && rej_valid));

  p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_code != 3'd0 && rej_code <= 3'd5));

  p_hold_egress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ts) && $stable(out_price)));

  p_hold_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_valid && !rej_ready) |=> (rej_valid && $stable(rej_code)));

  p_fixed_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> (out_valid || rej_valid));
endmodule

bind ord_risk_gate orq_gate_chk #(.PX_W(PX_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_price(out_price),
  .out_ts(out_ts), .rej_valid(rej_valid), .rej_ready(rej_ready),
  .rej_code(rej_code)
);

// File: tb/ord_risk_gate_bench.sv
`timescale 1ns/1ps
module ord_risk_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_side = 1'b0;
  logic        in_ready;
  logic [7:0]  in_sym = '0;
  logic [15:0] in_price = '0, in_qty = '0;
  logic [3:0]  in_client = '0;
  logic        out_valid, out_side, rej_valid;
  logic        out_ready = 1'b1, rej_ready = 1'b1;
  logic [7:0]  out_sym, rej_sym;
  logic [15:0] out_price, out_qty;
  logic [3:0]  out_client, rej_client;
  logic [31:0] out_ts;
  logic [2:0]  out_rule, rej_code;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        monitor_en = 1'b0, totals_clear = 1'b0;

  always #2.5 clk = ~clk;

  ord_risk_gate u_ord_risk_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .in_side(in_side), .in_price(in_price), .in_qty(in_qty),
    .in_client(in_client), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_side(out_side), .out_price(out_price),
    .out_qty(out_qty), .out_client(out_client), .out_ts(out_ts),
    .out_rule(out_rule), .rej_valid(rej_valid), .rej_ready(rej_ready),
    .rej_client(rej_client), .rej_sym(rej_sym), .rej_code(rej_code),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .monitor_en(monitor_en), .totals_clear(totals_clear)
  );

  typedef struct {
    logic [7:0]  sym;
    logic        side;
    logic [15:0] px;
    logic [15:0] qty;
    logic [3:0]  cl;
    logic [2:0]  code;
    int unsigned ts;
    bit          ts_chk;
    string       req;
  } exp_t;

  exp_t eg_q[$];
  exp_t rj_q[$];
  exp_t mon_e;

  int n_chk = 0, n_err = 0;
  int unsigned tc;
  bit ts_exact = 1'b1;
  bit done = 1'b0;

  // reference model state
  longint m_pxl = 32'hFFFF_FFFF, m_qtl = 32'hFFFF_FFFF;
  longint m_crl = 32'hFFFF_FFFF, m_vol = 32'hFFFF_FFFF;
  bit [255:0] m_blk = '0;
  longint m_cr[16], m_vo[16];
  bit m_mon = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) tc <= 0;
    else        tc <= tc + 1;
  end

  function automatic void check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endfunction

  function automatic int ref_code(logic [7:0] s, logic [15:0] p, logic [15:0] q, logic [3:0] c);
    longint ex = longint'(p) * longint'(q);
    if (longint'(p) > m_pxl) return 1;
    if (q == 0 || longint'(q) > m_qtl) return 2;
    if (m_cr[c] + ex > m_crl) return 3;
    if (m_blk[s]) return 4;
    if (m_vo[c] + longint'(q) > m_vol) return 5;
    return 0;
  endfunction

  task automatic send(input logic [7:0] s, input logic sd, input logic [15:0] p,
                      input logic [15:0] q, input logic [3:0] c, input string req);
    exp_t e;
    int code;
    in_sym = s; in_side = sd; in_price = p; in_qty = q; in_client = c;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    code = ref_code(s, p, q, c);
    e.sym = s; e.side = sd; e.px = p; e.qty = q; e.cl = c;
    e.code = 3'(code); e.ts = tc + 2; e.ts_chk = ts_exact; e.req = req;
    if (code == 0 || m_mon) eg_q.push_back(e);
    else                    rj_q.push_back(e);
    if (code == 0) begin
      m_cr[c] += longint'(p) * longint'(q);
      m_vo[c] += longint'(q);
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd0: m_pxl = d;
      4'd1: m_qtl = d;
      4'd2: m_crl = d;
      4'd3: m_vol = d;
      default: if (a[3]) m_blk[a[2:0]*32 +: 32] = d;
    endcase
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic drain();
    while (eg_q.size() != 0 || rj_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk); #1;
    if (rst_n && out_valid && out_ready) begin
      if (eg_q.size() == 0) check(1'b0, "R4", "unexpected egress price", out_price, 0);
      else begin
        mon_e = eg_q.pop_front();
        check(out_rule == mon_e.code, mon_e.req, "egress rule code", out_rule, mon_e.code);
        check(out_price == mon_e.px && out_qty == mon_e.qty && out_client == mon_e.cl &&
              out_sym == mon_e.sym && out_side == mon_e.side,
              mon_e.req, "egress fields (price)", out_price, mon_e.px);
        if (mon_e.ts_chk) begin
          check(out_ts == mon_e.ts, "R4", "egress timestamp", out_ts, mon_e.ts);
          check(tc == mon_e.ts + 1, "R3", "result cycle", tc, mon_e.ts + 1);
        end
      end
    end
    if (rst_n && rej_valid && rej_ready) begin
      if (rj_q.size() == 0) check(1'b0, "R5", "unexpected reject code", rej_code, 0);
      else begin
        mon_e = rj_q.pop_front();
        check(rej_code == mon_e.code, mon_e.req, "reject code", rej_code, mon_e.code);
        check(rej_client == mon_e.cl && rej_sym == mon_e.sym, "R5", "reject client",
              rej_client, mon_e.cl);
        if (mon_e.ts_chk)
          check(tc == mon_e.ts + 1, "R3", "reject cycle", tc, mon_e.ts + 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not complete, cycles", 100000, 0);
    finish_up();
  end

  initial begin
    logic [31:0] held_ts;
    for (int i = 0; i < 16; i++) begin m_cr[i] = 0; m_vo[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12: reset state
    check(!out_valid && !rej_valid, "R12", "outputs valid after reset", out_valid | rej_valid, 0);
    check(in_ready, "R12", "in_ready after reset", in_ready, 1);

    // R4: pass with default (all-ones) limits
    send(8'd10, 1'b0, 16'd100, 16'd10, 4'd1, "R4");
    drain();

    // R11: program limits
    cfg_write(4'd0, 32'd1000);
    cfg_write(4'd1, 32'd500);
    cfg_write(4'd2, 32'd100000);
    cfg_write(4'd3, 32'd1000);
    cfg_write(4'd9, 32'h0000_0020);   // symbol 37 restricted

    // R1: individual rules, back to back
    send(8'd11, 1'b1, 16'd1001, 16'd10, 4'd2, "R1");
    send(8'd11, 1'b0, 16'd1000, 16'd501, 4'd2, "R1");
    send(8'd11, 1'b0, 16'd10, 16'd0, 4'd2, "R1");
    send(8'd37, 1'b0, 16'd10, 16'd10, 4'd2, "R1");
    send(8'd36, 1'b1, 16'd10, 16'd10, 4'd2, "R11");
    send(8'd38, 1'b0, 16'd10, 16'd10, 4'd2, "R11");
    // R2: several rules at once
    send(8'd37, 1'b0, 16'd2000, 16'd0, 4'd2, "R2");
    send(8'd37, 1'b0, 16'd10, 16'd600, 4'd2, "R2");
    drain();

    // R7: credit accumulates per client, rejected order adds nothing, equality passes
    send(8'd20, 1'b0, 16'd100, 16'd400, 4'd3, "R7");
    send(8'd20, 1'b0, 16'd100, 16'd400, 4'd3, "R7");
    send(8'd20, 1'b0, 16'd100, 16'd400, 4'd3, "R7");
    send(8'd20, 1'b0, 16'd100, 16'd200, 4'd3, "R7");
    send(8'd20, 1'b0, 16'd100, 16'd1, 4'd3, "R7");
    send(8'd20, 1'b0, 16'd100, 16'd1, 4'd6, "R7");
    // R8: volume per client
    send(8'd21, 1'b0, 16'd1, 16'd400, 4'd4, "R8");
    send(8'd21, 1'b0, 16'd1, 16'd400, 4'd4, "R8");
    send(8'd21, 1'b0, 16'd1, 16'd400, 4'd4, "R8");
    send(8'd21, 1'b0, 16'd1, 16'd200, 4'd4, "R8");
    send(8'd21, 1'b0, 16'd1, 16'd1, 4'd4, "R8");
    drain();

    // R6: monitor-only mode
    monitor_en = 1'b1; m_mon = 1'b1;
    send(8'd22, 1'b0, 16'd1001, 16'd5, 4'd7, "R6");
    send(8'd37, 1'b1, 16'd5, 16'd5, 4'd7, "R6");
    send(8'd22, 1'b0, 16'd5, 16'd5, 4'd7, "R6");
    send(8'd22, 1'b0, 16'd5, 16'd1, 4'd4, "R6");
    drain();
    monitor_en = 1'b0; m_mon = 1'b0;

    // R10: clear totals
    send(8'd23, 1'b0, 16'd100, 16'd10, 4'd3, "R7");
    drain();
    @(negedge clk); totals_clear = 1'b1;
    @(negedge clk); totals_clear = 1'b0;
    for (int i = 0; i < 16; i++) begin m_cr[i] = 0; m_vo[i] = 0; end
    send(8'd23, 1'b0, 16'd100, 16'd10, 4'd3, "R10");
    send(8'd23, 1'b0, 16'd1, 16'd900, 4'd4, "R10");
    drain();

    // R11: limit write in the same cycle as an order applies to the next order only
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'd500;
    send(8'd24, 1'b0, 16'd800, 16'd1, 4'd8, "R11");
    cfg_we = 1'b0;
    model_write(4'd0, 32'd500);
    send(8'd24, 1'b0, 16'd800, 16'd1, 4'd8, "R11");
    send(8'd24, 1'b0, 16'd500, 16'd1, 4'd8, "R11");
    drain();

    // R9: egress stall
    ts_exact = 1'b0;
    @(negedge clk); out_ready = 1'b0;
    fork
      begin
        send(8'd50, 1'b0, 16'd10, 16'd10, 4'd5, "R9");
        send(8'd51, 1'b1, 16'd11, 16'd10, 4'd5, "R9");
        send(8'd52, 1'b0, 16'd12, 16'd10, 4'd5, "R9");
        send(8'd53, 1'b0, 16'd13, 16'd10, 4'd5, "R9");
      end
      begin
        repeat (6) @(negedge clk);
        #1;
        check(!in_ready && out_valid, "R9", "in_ready while egress held", in_ready, 0);
        held_ts = out_ts;
        @(negedge clk); #1;
        check(out_valid && out_ts == held_ts && out_price == 16'd10, "R9",
              "held egress stamp", out_ts, held_ts);
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    drain();

    // R9: reject stall
    @(negedge clk); rej_ready = 1'b0;
    fork
      begin
        send(8'd60, 1'b0, 16'd900, 16'd1, 4'd9, "R9");
        send(8'd61, 1'b0, 16'd10, 16'd0, 4'd9, "R9");
        send(8'd62, 1'b0, 16'd10, 16'd1, 4'd9, "R9");
      end
      begin
        repeat (6) @(negedge clk);
        #1;
        check(!in_ready && rej_valid && rej_code == 3'd1, "R9", "in_ready while reject held",
              in_ready, 0);
        @(negedge clk);
        rej_ready = 1'b1;
      end
    join
    drain();

    check(eg_q.size() == 0 && rj_q.size() == 0, "R5", "items left in scoreboard",
          eg_q.size() + rj_q.size(), 0);
    finish_up();
  end
endmodule